// File: doc/BRIEF.md
# Binary64 NaN Classifier and Quieter

This unit inspects one 64-bit IEEE 754 binary64 operand per transfer. It reports which of six classes the operand belongs to, and it turns a signaling NaN into a quiet NaN. A mode bit travels with each operand and selects how the quiet bit is read. In standard mode, a set quiet bit means quiet. In legacy mode the meaning is inverted, so a set quiet bit means signaling. Every result that came from a signaling NaN raises an invalid-operation pulse. The unit only reports this event and does not store it. Any other operand passes through untouched.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. An input beat transfers on a cycle where `in_valid` and `in_ready` are both high. An output beat transfers on a cycle where `out_valid` and `out_ready` are both high. When the output register is enabled, it holds one result. `in_ready` stays high while that register is empty or while its result is leaving in the same cycle. While the consumer holds `out_ready` low, the stored result does not change. When the register is disabled, the path is purely combinational and `in_ready` simply follows `out_ready`.

Top module: `dpnq_unit`

## Requirements
- R1: `out_class` is one-hot whenever `out_valid` is high. The bit positions are: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN.
- R2: The exponent field is bits 62:52 and the fraction field is bits 51:0. An exponent of zero gives zero when the fraction is zero and subnormal otherwise. An exponent of all ones (0x7FF) gives infinity when the fraction is zero and NaN otherwise. Every other exponent gives normal.
- R3: For a NaN, the quiet-bit indicator is fraction bit 51 (word bit 51). With `std_mode`=1 the NaN is signaling when that bit is 0. With `std_mode`=0 it is signaling when that bit is 1. In general, the NaN is signaling when `std_mode` XOR bit 51 equals 1.
- R4: With `std_mode`=1, a signaling NaN is quieted by setting bit 51.
- R5: With `std_mode`=0, a signaling NaN is quieted by clearing bit 51. If the fraction is then all zero, bit 50 is also set, so that the result stays a NaN and does not become infinity.
- R6: Quieting never changes the sign bit, the exponent or the other fraction bits. An operand that is not a signaling NaN leaves unchanged.
- R7: `invalid_pulse` is high only in a cycle where an output beat derived from a signaling NaN transfers. It is high for exactly that one cycle per such beat.
- R8: With the output register enabled, a result appears on the cycle after its input transfers. While `out_valid` is high and `out_ready` is low, the held result, its class and its flag stay stable, and `in_ready` is low. The `std_mode` value sampled is the one present at input transfer.
- R9: During and immediately after reset, `out_valid` and `invalid_pulse` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can accept an operand |
| in_data | input | 64 | Binary64 operand |
| std_mode | input | 1 | 1: standard quiet-bit meaning, 0: legacy inverted meaning |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Quieted or unchanged operand |
| out_class | output | 6 | One-hot class of the operand |
| invalid_pulse | output | 1 | Invalid-operation event, one cycle per accepted signaling result |

## Verification
The bench builds the unit with `REG_OUT`=1. This setting brings the one-cycle latency, the stall-hold behaviour and the back-pressure on `in_ready` within reach, including a new operand that waits while a held signaling result is pending. The vector table covers every class under both modes. It includes the legacy case where clearing the quiet bit would leave a zero fraction, which exercises the bit-50 repair.

// File: rtl/dpnq_pkg.sv
package dpnq_pkg;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int CLASS_W = 6;

  // one-hot class bit positions
  localparam int CLS_ZERO = 0;
  localparam int CLS_SUB  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_QNAN = 4;
  localparam int CLS_SNAN = 5;
endpackage

// File: rtl/dpnq_classify.sv
module dpnq_classify
  import dpnq_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0]      operand,
  input  logic                std_mode,
  output logic [CLASS_W-1:0]  cls
);
  localparam int QB = FW - 1;

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic exp_ones, exp_zero, frac_zero, is_nan, is_sig;

  assign exp_f     = operand[EW+FW-1:FW];
  assign frac_f    = operand[FW-1:0];
  assign exp_ones  = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;
  assign is_nan    = exp_ones & ~frac_zero;
  assign is_sig    = std_mode ^ frac_f[QB];

  always_comb begin
    cls = '0;
    cls[CLS_ZERO] = exp_zero & frac_zero;
    cls[CLS_SUB]  = exp_zero & ~frac_zero;
    cls[CLS_NORM] = ~exp_zero & ~exp_ones;
    cls[CLS_INF]  = exp_ones & frac_zero;
    cls[CLS_QNAN] = is_nan & ~is_sig;
    cls[CLS_SNAN] = is_nan & is_sig;
  end
endmodule

// File: rtl/dpnq_quiet.sv
module dpnq_quiet
  import dpnq_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] operand,
  input  logic           std_mode,
  input  logic           is_snan,
  output logic [EW+FW:0] result
);
  localparam int QB = FW - 1;
  localparam int RB = FW - 2;

  logic [FW-1:0] frac_std, frac_leg;

  always_comb begin
    frac_std     = operand[FW-1:0];
    frac_std[QB] = 1'b1;
    frac_leg     = operand[FW-1:0];
    frac_leg[QB] = 1'b0;
    if (frac_leg == '0) frac_leg[RB] = 1'b1;
  end

  always_comb begin
    result = operand;
    if (is_snan) result[FW-1:0] = std_mode ? frac_std : frac_leg;
  end

  always_comb begin
    AST_PASS_UNCHANGED: assert (is_snan || result == operand); // R6
    AST_STAYS_NAN: assert (!is_snan || ((&result[EW+FW-1:FW]) && (|result[FW-1:0]))); // R5
    AST_SIGN_EXP_KEPT: assert (result[EW+FW:FW] == operand[EW+FW:FW]); // R6
    AST_STD_QBIT_SET: assert (!(is_snan && std_mode) || result[QB]); // R4
  end
endmodule

// File: rtl/dpnq_outstage.sv
module dpnq_outstage #(
  parameter int PW      = 71,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_payload,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [PW-1:0] m_payload
);
  generate
    if (REG_OUT) begin : g_reg
      logic          full;
      logic [PW-1:0] held;
      assign s_ready   = !full || m_ready;
      assign m_valid   = full;
      assign m_payload = held;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full <= 1'b0;
          held <= '0;
        end else if (s_ready) begin
          full <= s_valid;
          if (s_valid) held <= s_payload;
        end
      end

      AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !m_ready) |=> (full && $stable(held))); // R8
      AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !m_ready) |-> !s_ready); // R8
    end else begin : g_comb
      assign s_ready   = m_ready;
      assign m_valid   = s_valid;
      assign m_payload = s_payload;
    end
  endgenerate
endmodule

// File: rtl/dpnq_unit.sv
module dpnq_unit
  import dpnq_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                std_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic [CLASS_W-1:0]  out_class,
  output logic                invalid_pulse
);
  localparam int PW = WORD_W + CLASS_W;

  logic [CLASS_W-1:0] cls_c;
  logic [WORD_W-1:0]  res_c;
  logic [PW-1:0]      pay_out;

  dpnq_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
    .operand(in_data), .std_mode(std_mode), .cls(cls_c));

  dpnq_quiet #(.EW(EXP_W), .FW(FRAC_W)) u_qt (
    .operand(in_data), .std_mode(std_mode), .is_snan(cls_c[CLS_SNAN]),
    .result(res_c));

  dpnq_outstage #(.PW(PW), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_payload({cls_c, res_c}),
    .m_valid(out_valid), .m_ready(out_ready), .m_payload(pay_out));

  assign out_class     = pay_out[PW-1:WORD_W];
  assign out_data      = pay_out[WORD_W-1:0];
  assign invalid_pulse = out_valid && out_ready && out_class[CLS_SNAN];

  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_class) == 1)); // R1
  AST_PULSE_ON_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_pulse |-> (out_valid && out_ready && out_class[CLS_SNAN])); // R7
  AST_SNAN_OUT_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class[CLS_SNAN]) |-> ((&out_data[WORD_W-2:FRAC_W]) && (|out_data[FRAC_W-1:0]))); // R5
endmodule

// File: tb/dpnq_unit_test.sv
module dpnq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        std_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [5:0]  out_class;
  logic        invalid_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpnq_unit #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .std_mode(std_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_class(out_class),
    .invalid_pulse(invalid_pulse));

  // {mode, operand, expected result, expected class}
  localparam int NV = 17;
  localparam logic [134:0] VEC [NV] = '{
    {1'b0, 64'h0000000000000000, 64'h0000000000000000, 6'b000001},
    {1'b1, 64'h8000000000000000, 64'h8000000000000000, 6'b000001},
    {1'b1, 64'h0000000000000001, 64'h0000000000000001, 6'b000010},
    {1'b0, 64'h800FFFFFFFFFFFFF, 64'h800FFFFFFFFFFFFF, 6'b000010},
    {1'b1, 64'h3FF0000000000000, 64'h3FF0000000000000, 6'b000100},
    {1'b0, 64'hFFEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 6'b000100},
    {1'b1, 64'h7FF0000000000000, 64'h7FF0000000000000, 6'b001000},
    {1'b0, 64'hFFF0000000000000, 64'hFFF0000000000000, 6'b001000},
    {1'b1, 64'h7FF8000000000000, 64'h7FF8000000000000, 6'b010000},
    {1'b1, 64'h7FF0000000000001, 64'h7FF8000000000001, 6'b100000},
    {1'b1, 64'hFFF4000000000000, 64'hFFFC000000000000, 6'b100000},
    {1'b0, 64'h7FF0000000000001, 64'h7FF0000000000001, 6'b010000},
    {1'b0, 64'h7FF8000000000001, 64'h7FF0000000000001, 6'b100000},
    {1'b0, 64'hFFF8000000000000, 64'hFFF4000000000000, 6'b100000},
    {1'b0, 64'h7FFC000000000000, 64'h7FF4000000000000, 6'b100000},
    {1'b1, 64'h7FFFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF, 6'b010000},
    {1'b0, 64'h7FF7FFFFFFFFFFFF, 64'h7FF7FFFFFFFFFFFF, 6'b010000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic mode, input logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    std_mode = mode;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R9 pulse in reset", {63'd0, invalid_pulse}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R9 in_ready after reset", {63'd0, in_ready}, 64'd1);

    // table walk, consumer always ready
    out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic        m;
      logic [63:0] opd, exp_d;
      logic [5:0]  exp_c;
      {m, opd, exp_d, exp_c} = VEC[i];
      send(m, opd);
      check("R8 out_valid one cycle after transfer", {63'd0, out_valid}, 64'd1);
      check("R1 R2 R3 class", {58'd0, out_class}, {58'd0, exp_c});
      if (!exp_c[5])      check("R6 unchanged", out_data, exp_d);
      else if (m)         check("R4 standard quieting", out_data, exp_d);
      else                check("R5 legacy quieting", out_data, exp_d);
      check("R7 pulse", {63'd0, invalid_pulse}, {63'd0, exp_c[5]});
    end
    @(negedge clk);
    check("R7 no pulse when idle", {63'd0, invalid_pulse}, 64'd0);

    // R8 stall: signaling result held while consumer not ready
    out_ready = 1'b0;
    send(1'b0, 64'hFFF8000000000000);
    check("R8 held valid", {63'd0, out_valid}, 64'd1);
    check("R7 no pulse while stalled", {63'd0, invalid_pulse}, 64'd0);
    check("R8 in_ready low when full", {63'd0, in_ready}, 64'd0);
    held = out_data;
    // offer a new operand and flip mode while stalled
    in_valid = 1'b1;
    std_mode = 1'b1;
    in_data  = 64'h7FF0000000000001;
    @(negedge clk);
    check("R8 data stable in stall", out_data, held);
    check("R5 stalled legacy result", out_data, 64'hFFF4000000000000);
    check("R7 still no pulse", {63'd0, invalid_pulse}, 64'd0);
    out_ready = 1'b1;
    #1;
    check("R7 pulse on release", {63'd0, invalid_pulse}, 64'd1);
    check("R8 in_ready on release", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 waiting operand taken", out_data, 64'h7FF8000000000001);
    check("R7 second pulse", {63'd0, invalid_pulse}, 64'd1);
    @(negedge clk);
    check("R8 empty after drain", {63'd0, out_valid}, 64'd0);

    // R9 reset mid-stream clears the held beat
    out_ready = 1'b0;
    send(1'b1, 64'h7FF0000000000001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset clears pulse", {63'd0, invalid_pulse}, 64'd0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule